// File: doc/BRIEF.md
# Configuration Register Space with Write Filtering

This block holds the 256-byte configuration space of function 0 of a bus bridge. Requests arrive one byte at a time and carry a function number and a register offset. A write, when `acc_wr` is high, lands on the rising clock edge. A read is combinational. It returns the stored byte after per-offset masking.

Writes pass through a filter before they reach storage. Any non-zero function number is refused, as is a wide protected band of offsets that has one hole. A small set of identity bytes is read-only. Four routing bytes accept writes only when the revision input is at or above a threshold. The command byte has forced bits, and a few status-like bytes read as fixed constants. Bit 6 of two particular bytes is reflected on dedicated enable outputs. One output switches DMA address aliasing and the other switches a fast-reset/A20 port. The logic that these outputs control is not part of the block.

Reset is asynchronous and active-low. Its release is synchronised over two clock edges, so writes are accepted from the third rising edge after `rst_n` goes high.

Top module: `cfgspace_filter`

## Requirements
- R1: After reset, the following offsets hold these values: 0x40 = 0x20, 0x4F = 0x4F, each of 0x60..0x63 = 0x80, 0x80 = 0x78 and 0x81 = 0x00. Every other stored offset reads 0x00. After reset, `dma_alias_en` is 0 and `fast_port_en` is 1.
- R2: When `acc_fn` is not 0, a read returns 0xFF and a write changes nothing.
- R3: Writes to offsets 0x0F through 0x4B are dropped, with one exception: offset 0x40 is writable.
- R4: Offsets 0x00..0x03 read byte k of parameter `ID_WORD`, taken from bits [8k+7:8k] for offset k. Offsets 0x09..0x0B and 0x0E read 0x00. Writes to any of these offsets have no effect.
- R5: Offset 0x04 reads {4'b0000, stored bit 3, 3'b111}. Only bit 3 can be changed by a write.
- R6: Offsets 0x05 and 0x06 always read 0x00, and offset 0x07 always reads 0x02, whatever is written to them.
- R7: Offset 0x08 reads the current value of `rev_id`.
- R8: A write to offsets 0x60..0x63 is ignored when `rev_id` is below `REV_GATE` (default 3). When `rev_id` is at or above `REV_GATE`, the write is stored.
- R9: `dma_alias_en` is a registered copy of bit 6 of offset 0x40. It changes on the clock edge of a write that alters that bit.
- R10: `fast_port_en` is a registered copy of bit 6 of offset 0x4F. It changes on the clock edge of a write that alters that bit.
- R11: Every other offset (0x0C, 0x0D, 0x40, and 0x4C..0xFF) stores and reads back the full byte written.
- R12: A write becomes visible on the read path only after its clock edge. A read of the same offset in the cycle of the write returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_fn | input | 3 | Function number of the access |
| acc_off | input | 8 | Register offset of the access |
| acc_wr | input | 1 | Write strobe; the write is applied on the rising edge |
| acc_wdata | input | 8 | Write data byte |
| rev_id | input | 8 | Silicon revision value |
| acc_rdata | output | 8 | Combinational read data for `acc_fn`/`acc_off` |
| dma_alias_en | output | 1 | DMA address alias enable (bit 6 of offset 0x40) |
| fast_port_en | output | 1 | Fast reset/A20 port enable (bit 6 of offset 0x4F) |

## Verification
The bench targets the edges of the protected band.

- Offsets 0x0E, 0x0F, 0x40, 0x4B and 0x4C sit on those edges. An off-by-one in the range decode would either store a byte that must stay fixed, or refuse a writable one.
- Routing bytes are written with `rev_id` on both sides of the threshold. A reversed comparison would store the bytes on the old revision and drop them on the new one.
- The command byte and the fixed status bytes are hit with all-ones and all-zeros data. A missing mask would leak the written bits onto the read path.
- The enable outputs are tracked against a model after each write to 0x40 and 0x4F. A wrong bit index, or an enable taken from the wrong offset, would leave an output out of step with what software wrote.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int CFG_AW = 8;
  localparam int CFG_DW = 8;
  localparam int CFG_FW = 3;
  localparam int CFG_NB = 1 << CFG_AW;

  localparam logic [CFG_AW-1:0] OFF_CMD      = 8'h04;
  localparam logic [CFG_AW-1:0] OFF_REV      = 8'h08;
  localparam logic [CFG_AW-1:0] OFF_ALIAS    = 8'h40;
  localparam logic [CFG_AW-1:0] OFF_PORT     = 8'h4F;
  localparam logic [CFG_AW-1:0] OFF_PROT_LO  = 8'h0F;
  localparam logic [CFG_AW-1:0] OFF_PROT_HI  = 8'h4B;
  localparam logic [CFG_AW-1:0] OFF_ROUTE_LO = 8'h60;
  localparam logic [CFG_AW-1:0] OFF_ROUTE_HI = 8'h63;
  localparam int               EN_BIT        = 6;

  // Value a byte takes at reset (and keeps for ever if it has no storage).
  function automatic logic [CFG_DW-1:0] cfg_reset_val(int idx);
    logic [CFG_DW-1:0] v;
    v = '0;
    if (idx == int'(OFF_ALIAS))                                   v = 8'h20;
    else if (idx == int'(OFF_PORT))                               v = 8'h4F;
    else if (idx >= int'(OFF_ROUTE_LO) && idx <= int'(OFF_ROUTE_HI)) v = 8'h80;
    else if (idx == 8'h80)                                        v = 8'h78;
    else if (idx == int'(OFF_CMD))                                v = 8'h07;
    return v;
  endfunction

  // True when a byte needs flops: any offset a write can ever change.
  function automatic bit cfg_is_stored(int idx);
    bit s;
    s = (idx == int'(OFF_CMD)) || (idx == 8'h0C) || (idx == 8'h0D) ||
        (idx == int'(OFF_ALIAS)) || (idx > int'(OFF_PROT_HI));
    return s;
  endfunction
endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/cfg_wr_filter.sv
module cfg_wr_filter
  import cfg_pkg::*;
#(
  parameter int REV_GATE = 3
) (
  input  logic              wr_req,
  input  logic [CFG_FW-1:0] fn,
  input  logic [CFG_AW-1:0] off,
  input  logic [CFG_DW-1:0] rev,
  output logic              wr_ok
);
  logic in_prot_band;
  logic is_ro;
  logic is_route;
  logic rev_low;

  always_comb begin
    in_prot_band = (off >= OFF_PROT_LO) && (off <= OFF_PROT_HI) && (off != OFF_ALIAS);
    is_ro        = (off <= 8'h03) || ((off >= 8'h08) && (off <= 8'h0B)) || (off == 8'h0E);
    is_route     = (off >= OFF_ROUTE_LO) && (off <= OFF_ROUTE_HI);
    rev_low      = (int'(rev) < REV_GATE);
    wr_ok        = wr_req && (fn == '0) && !in_prot_band && !is_ro && !(is_route && rev_low);
  end
endmodule

// File: rtl/cfg_byte_array.sv
module cfg_byte_array
  import cfg_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_ok,
  input  logic [CFG_AW-1:0]        wr_off,
  input  logic [CFG_DW-1:0]        wr_data,
  output logic [CFG_NB*CFG_DW-1:0] bytes_flat
);
  for (genvar i = 0; i < CFG_NB; i++) begin : g_byte
    if (cfg_is_stored(i)) begin : g_ff
      logic [CFG_DW-1:0] q;
      logic [CFG_DW-1:0] d;
      logic              ce;

      always_comb begin
        ce = wr_ok && (wr_off == CFG_AW'(i));
        d  = ce ? wr_data : q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= cfg_reset_val(i);
        else        q <= d;
      end

      assign bytes_flat[i*CFG_DW +: CFG_DW] = q;
    end else begin : g_const
      assign bytes_flat[i*CFG_DW +: CFG_DW] = cfg_reset_val(i);
    end
  end
endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_pkg::*;
#(
  parameter logic [31:0] ID_WORD = 32'h7A31_C0DE
) (
  input  logic [CFG_FW-1:0]        fn,
  input  logic [CFG_AW-1:0]        off,
  input  logic [CFG_DW-1:0]        rev,
  input  logic [CFG_NB*CFG_DW-1:0] bytes_flat,
  output logic [CFG_DW-1:0]        rdata
);
  logic [CFG_DW-1:0] raw;

  always_comb begin
    raw = bytes_flat[{off, 3'b000} +: CFG_DW];
    if (fn != '0) begin
      rdata = 8'hFF;
    end else begin
      unique case (off)
        8'h00, 8'h01, 8'h02, 8'h03: rdata = ID_WORD[{off[1:0], 3'b000} +: CFG_DW];
        OFF_REV:                    rdata = rev;
        8'h09, 8'h0A, 8'h0B, 8'h0E: rdata = 8'h00;
        OFF_CMD:                    rdata = {4'b0000, raw[3], 3'b111};
        8'h05, 8'h06:               rdata = 8'h00;
        8'h07:                      rdata = 8'h02;
        default:                    rdata = raw;
      endcase
    end
  end
endmodule

// File: rtl/cfg_bit_track.sv
module cfg_bit_track
  import cfg_pkg::*;
#(
  parameter logic [CFG_AW-1:0] OFFSET  = 8'h40,
  parameter int                BIT_IDX = 6,
  parameter logic              RST_VAL = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ok,
  input  logic [CFG_AW-1:0] wr_off,
  input  logic [CFG_DW-1:0] wr_data,
  output logic              en_q
);
  logic hit;
  logic en_d;

  always_comb begin
    hit  = wr_ok && (wr_off == OFFSET) && (wr_data[BIT_IDX] != en_q);
    en_d = hit ? wr_data[BIT_IDX] : en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= RST_VAL;
    else        en_q <= en_d;
  end
endmodule

// File: rtl/cfgspace_filter.sv
module cfgspace_filter
  import cfg_pkg::*;
#(
  parameter int          REV_GATE = 3,
  parameter logic [31:0] ID_WORD  = 32'h7A31_C0DE
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] acc_fn,
  input  logic [7:0] acc_off,
  input  logic       acc_wr,
  input  logic [7:0] acc_wdata,
  input  logic [7:0] rev_id,
  output logic [7:0] acc_rdata,
  output logic       dma_alias_en,
  output logic       fast_port_en
);
  localparam logic ALIAS_RST = cfg_reset_val(int'(OFF_ALIAS))[EN_BIT];
  localparam logic PORT_RST  = cfg_reset_val(int'(OFF_PORT))[EN_BIT];

  logic                     rst_i_n;
  logic                     wr_ok;
  logic [CFG_NB*CFG_DW-1:0] bytes_flat;

  cfg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  cfg_wr_filter #(.REV_GATE(REV_GATE)) u_filt (
    .wr_req (acc_wr),
    .fn     (acc_fn),
    .off    (acc_off),
    .rev    (rev_id),
    .wr_ok  (wr_ok)
  );

  cfg_byte_array u_arr (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .wr_ok      (wr_ok),
    .wr_off     (acc_off),
    .wr_data    (acc_wdata),
    .bytes_flat (bytes_flat)
  );

  cfg_rd_mux #(.ID_WORD(ID_WORD)) u_rd (
    .fn         (acc_fn),
    .off        (acc_off),
    .rev        (rev_id),
    .bytes_flat (bytes_flat),
    .rdata      (acc_rdata)
  );

  cfg_bit_track #(.OFFSET(OFF_ALIAS), .BIT_IDX(EN_BIT), .RST_VAL(ALIAS_RST)) u_alias (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_ok   (wr_ok),
    .wr_off  (acc_off),
    .wr_data (acc_wdata),
    .en_q    (dma_alias_en)
  );

  cfg_bit_track #(.OFFSET(OFF_PORT), .BIT_IDX(EN_BIT), .RST_VAL(PORT_RST)) u_port (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_ok   (wr_ok),
    .wr_off  (acc_off),
    .wr_data (acc_wdata),
    .en_q    (fast_port_en)
  );
endmodule

// File: rtl/cfgspace_filter_chk.sv
module cfgspace_filter_chk (
  input logic       clk,
  input logic       rst_i_n,
  input logic [2:0] acc_fn,
  input logic [7:0] acc_off,
  input logic       acc_wr,
  input logic [7:0] acc_wdata,
  input logic [7:0] rev_id,
  input logic [7:0] acc_rdata,
  input logic       dma_alias_en,
  input logic       fast_port_en
);
  logic wr40;
  logic wr4f;
  assign wr40 = acc_wr && (acc_fn == 3'd0) && (acc_off == 8'h40);
  assign wr4f = acc_wr && (acc_fn == 3'd0) && (acc_off == 8'h4F);

  AST_FN_NONZERO_FF: assert property (@(posedge clk) disable iff (!rst_i_n)
    (acc_fn != 3'd0) |-> (acc_rdata == 8'hFF)); // R2

  AST_CMD_FORCED: assert property (@(posedge clk) disable iff (!rst_i_n)
    (acc_fn == 3'd0 && acc_off == 8'h04) |-> (acc_rdata[2:0] == 3'b111 && acc_rdata[7:4] == 4'h0)); // R5

  AST_FIXED_STATUS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (acc_fn == 3'd0 && acc_off == 8'h07) |-> (acc_rdata == 8'h02)); // R6

  AST_REV_READ: assert property (@(posedge clk) disable iff (!rst_i_n)
    (acc_fn == 3'd0 && acc_off == 8'h08) |-> (acc_rdata == rev_id)); // R7

  AST_ALIAS_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr40 |=> (dma_alias_en == $past(acc_wdata[6]))); // R9

  AST_ALIAS_HOLDS: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wr40 |=> $stable(dma_alias_en)); // R9

  AST_PORT_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_i_n)
    wr4f |=> (fast_port_en == $past(acc_wdata[6]))); // R10

  AST_PORT_HOLDS: assert property (@(posedge clk) disable iff (!rst_i_n)
    !wr4f |=> $stable(fast_port_en)); // R10
endmodule

bind cfgspace_filter cfgspace_filter_chk u_chk (
  .clk          (clk),
  .rst_i_n      (rst_i_n),
  .acc_fn       (acc_fn),
  .acc_off      (acc_off),
  .acc_wr       (acc_wr),
  .acc_wdata    (acc_wdata),
  .rev_id       (rev_id),
  .acc_rdata    (acc_rdata),
  .dma_alias_en (dma_alias_en),
  .fast_port_en (fast_port_en)
);

// File: tb/sim_cfgspace_filter.sv
`timescale 1ns/1ps
module sim_cfgspace_filter;
  localparam logic [31:0] ID = 32'h7A31_C0DE;
  localparam int GATE = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] acc_fn = '0;
  logic [7:0] acc_off = '0;
  logic       acc_wr = 1'b0;
  logic [7:0] acc_wdata = '0;
  logic [7:0] rev_id = 8'd2;
  logic [7:0] acc_rdata;
  logic       dma_alias_en;
  logic       fast_port_en;

  int checks = 0;
  int failures = 0;
  bit cmp_on = 0;
  bit done = 0;
  int rst_cnt = 0;
  byte unsigned mem [256];

  always #2.5 clk = ~clk;

  cfgspace_filter #(.REV_GATE(GATE), .ID_WORD(ID)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_fn(acc_fn), .acc_off(acc_off), .acc_wr(acc_wr),
    .acc_wdata(acc_wdata), .rev_id(rev_id), .acc_rdata(acc_rdata),
    .dma_alias_en(dma_alias_en), .fast_port_en(fast_port_en));

  // R1 reset image of the model
  task automatic model_reset();
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h40] = 8'h20; mem[8'h4F] = 8'h4F; mem[8'h80] = 8'h78; mem[8'h81] = 8'h00;
    for (int i = 8'h60; i <= 8'h63; i++) mem[i] = 8'h80;
  endtask

  function automatic bit model_takes(int f, int a, int r);
    if (f != 0) return 0;                                   // R2
    if (a >= 8'h0F && a <= 8'h4B && a != 8'h40) return 0;  // R3
    if (a <= 3 || (a >= 8 && a <= 8'h0B) || a == 8'h0E) return 0; // R4
    if (a >= 8'h60 && a <= 8'h63 && r < GATE) return 0;    // R8
    return 1;
  endfunction

  function automatic logic [7:0] model_read(int f, int a, logic [7:0] r);
    if (f != 0) return 8'hFF;
    if (a <= 3) return ID[a*8 +: 8];
    if (a == 8) return r;
    if ((a >= 9 && a <= 8'h0B) || a == 8'h0E) return 8'h00;
    if (a == 4) return {4'b0, mem[4][3], 3'b111};
    if (a == 5 || a == 6) return 8'h00;
    if (a == 7) return 8'h02;
    return mem[a];
  endfunction

  function automatic string tag_of(int f, int a, bit w);
    if (rst_cnt < 2) return "R1";
    if (f != 0) return "R2";
    if (a >= 8'h0F && a <= 8'h4B && a != 8'h40) return "R3";
    if (a <= 3 || (a >= 9 && a <= 8'h0B) || a == 8'h0E) return "R4";
    if (a == 4) return "R5";
    if (a >= 5 && a <= 7) return "R6";
    if (a == 8) return "R7";
    if (a >= 8'h60 && a <= 8'h63) return "R8";
    if (w) return "R12";
    return "R11";
  endfunction

  initial model_reset();

  // model update on every edge, mirroring the two-edge reset release
  always @(posedge clk) begin
    if (!rst_n) begin
      rst_cnt = 0; model_reset();
    end else if (rst_cnt < 2) begin
      rst_cnt++; model_reset();
    end else if (acc_wr && model_takes(acc_fn, acc_off, rev_id)) begin
      mem[acc_off] = acc_wdata;
    end
  end

  // compare against the model on every clock, mid-cycle
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      logic [7:0] exp_rd;
      exp_rd = model_read(acc_fn, acc_off, rev_id);
      checks++;
      if (acc_rdata !== exp_rd) begin
        failures++;
        $display("FAIL %s fn=%0d off=%02h rdata actual=%02h expected=%02h",
                 tag_of(acc_fn, acc_off, acc_wr), acc_fn, acc_off, acc_rdata, exp_rd);
      end
      checks++;
      if (dma_alias_en !== mem[8'h40][6]) begin
        failures++;
        $display("FAIL %s dma_alias_en actual=%0b expected=%0b",
                 (rst_cnt < 2) ? "R1" : "R9", dma_alias_en, mem[8'h40][6]);
      end
      checks++;
      if (fast_port_en !== mem[8'h4F][6]) begin
        failures++;
        $display("FAIL %s fast_port_en actual=%0b expected=%0b",
                 (rst_cnt < 2) ? "R1" : "R10", fast_port_en, mem[8'h4F][6]);
      end
    end
  end

  task automatic drive(input int f, input int a, input bit w, input int d);
    @(posedge clk); #1;
    acc_fn = 3'(f); acc_off = 8'(a); acc_wr = w; acc_wdata = 8'(d);
  endtask

  initial begin
    // R1: sweep every offset while held in reset
    repeat (2) @(posedge clk);
    cmp_on = 1;
    for (int a = 0; a < 256; a++) drive(0, a, 0, 0);
    drive(0, 0, 0, 0);
    rst_n = 1'b1;
    repeat (4) drive(0, 8'h40, 0, 0);
    // R3 R4 R5 R6 R11 R12: all-ones then all-zeros to every offset, old revision
    rev_id = 8'd2;
    for (int a = 0; a < 256; a++) begin drive(0, a, 1, 8'hFF); drive(0, a, 0, 0); end
    for (int a = 0; a < 256; a++) begin drive(0, a, 1, 8'h00); drive(0, a, 0, 0); end
    for (int a = 0; a < 256; a++) begin drive(0, a, 1, a ^ 8'h5A); drive(0, a, 0, 0); end
    // R8: routing bytes on both sides of the threshold
    for (int r = 1; r <= 4; r++) begin
      rev_id = 8'(r);
      for (int a = 8'h60; a <= 8'h63; a++) begin drive(0, a, 1, r * 8'h11 + a); drive(0, a, 0, 0); end
    end
    // R9 R10: toggle enable bits
    for (int k = 0; k < 6; k++) begin
      drive(0, 8'h40, 1, (k & 1) ? 8'h40 : 8'hBF); drive(0, 8'h40, 0, 0);
      drive(0, 8'h4F, 1, (k & 1) ? 8'hBF : 8'h40); drive(0, 8'h4F, 0, 0);
    end
    // R2: other functions write and read
    for (int f = 1; f < 8; f++)
      for (int a = 8'h3E; a < 8'h84; a++) begin drive(f, a, 1, 8'hC3); drive(0, a, 0, 0); end
    // mixed random traffic
    void'($urandom(32'd77));
    for (int n = 0; n < 6000; n++) begin
      int f;
      f = (($urandom % 5) == 0) ? int'($urandom % 8) : 0;
      rev_id = 8'($urandom % 6);
      drive(f, $urandom % 256, $urandom % 2, $urandom % 256);
    end
    drive(0, 0, 0, 0);
    @(posedge clk); #1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule